// File: doc/BRIEF.md
# Multiplexed Address/Data External Memory Port

This block is the master side of a narrow external memory bus in which sixteen shared pins carry first an address and then data. An internal requester hands it one 32-bit word request: an address, a direction, write data and a device width. The port splits the word into four byte transfers for an 8-bit device or two halfword transfers for a 16-bit device. It issues those transfers at consecutive external addresses. Read results are packed back into one 32-bit word, with the first transfer in the least significant bits.

Each external transfer has an optional address phase and a data phase. In the address phase the port asserts an address latch enable strobe so that an external latch can capture the upper part of the address. In the data phase it drives an active-low read or write strobe for a programmable number of clock cycles. The port remembers which address portion the external latch already holds. When the next transfer needs the same portion, it skips the address phase and goes straight to the data phase, which saves one cycle per transfer during sequential 8-bit accesses.

Top module: `mux_ad_port`

## Requirements
- R1: After reset, both data strobes are high, the latch strobe is inactive, both pin lanes are released (`ad_oe_o` = 2'b00) and `busy_o` is low.
- R2: In 8-bit mode the address phase drives address bits 15..8 on pins 7..0 and address bits 23..16 on pins 15..8, with both lanes enabled.
- R3: In 8-bit mode the data phase drives the data byte on pins 7..0 and address bits 7..0 on pins 15..8. A word request makes four transfers at addresses A, A+1, A+2 and A+3 (24-bit wrap).
- R4: In 16-bit mode the address phase drives address bits 15..0 and the data phase carries a halfword on all 16 pins. A word request makes two transfers at A and A+1, with the sum wrapping in 16 bits.
- R5: An address phase is issued only when the portion the external latch must hold differs from the portion last latched. That portion is bits 23..8 in 8-bit mode and bits 15..0 in 16-bit mode. The first transfer after reset, and the first after a change of device width, always latch. An address phase is always followed by a data phase.
- R6: The data strobe stays low for exactly N cycles, where N is `cfg_strobe_i` (2..31). Values 0 and 1 give 2 cycles. Consecutive transfers are separated by at least one cycle with both strobes high.
- R7: With `cfg_ale_low_i` = 0 the latch strobe is high during the address phase and low otherwise. With `cfg_ale_low_i` = 1 the polarity is inverted.
- R8: Packing is little-endian. Transfer k carries write bits [8k+7:8k] in 8-bit mode or [16k+15:16k] in 16-bit mode. Read data sampled on the last strobe cycle of transfer k lands in those same bits of `rdata_o`. `done_o` pulses for one cycle, the cycle after the last strobe ends.
- R9: During a read data phase the data lane is released: `ad_oe_o` = 2'b00 in 16-bit mode and 2'b10 in 8-bit mode, where the high lane keeps driving address bits 7..0. During a write data phase `ad_oe_o` = 2'b11.
- R10: While `cfg_en_i` is low, requests are ignored and do not alter the remembered latch contents. Dropping `cfg_en_i` during an access returns the port to idle on the next clock edge, with both strobes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_en_i | input | 1 | Port enable |
| cfg_ale_low_i | input | 1 | 1 = latch strobe active low |
| cfg_strobe_i | input | 5 | Data strobe length in cycles (2..31) |
| req_i | input | 1 | Request, accepted when idle and enabled |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_wide_i | input | 1 | 1 = 16-bit device, 0 = 8-bit device |
| req_addr_i | input | 24 | External start address |
| req_wdata_i | input | 32 | Word to write |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 32 | Packed read word |
| ale_o | output | 1 | Address latch enable strobe |
| rd_n_o | output | 1 | Active-low read strobe |
| wr_n_o | output | 1 | Active-low write strobe |
| ad_o | output | 16 | Shared pin output values |
| ad_oe_o | output | 2 | Output enable per byte lane (bit 1 = pins 15..8) |
| ad_i | input | 16 | Shared pin input values |

## Verification
A stale or corrupted record of the last latched address appears on the very next transfer. Either the latch strobe pulses one time too many or too few, or the external latch model holds the wrong upper bits, so the address rebuilt from the pins is wrong for that transfer. A wrong beat counter or lane selection shows up in the same request as a misplaced byte in `rdata_o`, or as the wrong write byte on the pins. A strobe counter fault changes the measured strobe width on the first data phase that follows. The bench rebuilds every external address from the pins through a modelled latch, so each of these faults is caught within one request.

// File: rtl/mxp_pkg.sv
package mxp_pkg;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_LATCH,
      PH_STROBE,
      PH_RECOV
   } mxp_phase_e;

   // Portion of the address that the external latch must hold
   function automatic logic [15:0] mxp_tag(input logic [23:0] a, input logic wide);
      return wide ? a[15:0] : a[23:8];
   endfunction

endpackage

// File: rtl/mxp_tag_track.sv
module mxp_tag_track #(
   parameter int TAG_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             upd_i,
   input  logic             wide_i,
   input  logic [TAG_W-1:0] tag_i,
   output logic             hit_o
);

   logic             valid_q;
   logic             wide_q;
   logic [TAG_W-1:0] tag_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         valid_q <= 1'b0;
         wide_q  <= 1'b0;
         tag_q   <= '0;
      end else if (upd_i) begin
         valid_q <= 1'b1;
         wide_q  <= wide_i;
         tag_q   <= tag_i;
      end
   end

   assign hit_o = valid_q && (wide_q == wide_i) && (tag_q == tag_i);

   // R5
   first_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      upd_i |=> hit_o || (wide_i != $past(wide_i)) || (tag_i != $past(tag_i)));

endmodule

// File: rtl/mxp_strobe_timer.sv
module mxp_strobe_timer #(
   parameter int LEN_W   = 5,
   parameter int MIN_LEN = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic [LEN_W-1:0] len_i,
   output logic             last_o
);

   localparam logic [LEN_W-1:0] MinL = LEN_W'(MIN_LEN);

   logic [LEN_W-1:0] cnt_q;
   logic [LEN_W-1:0] len_q;
   logic [LEN_W-1:0] eff_len;

   assign eff_len = (len_i < MinL) ? MinL : len_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         len_q <= MinL;
      end else if (start_i) begin
         cnt_q <= LEN_W'(1);
         len_q <= eff_len;
      end else if (cnt_q != '0 && cnt_q < len_q) begin
         cnt_q <= cnt_q + LEN_W'(1);
      end
   end

   assign last_o = (cnt_q == len_q);

   // R6
   strobe_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q <= len_q) && (len_q >= MinL));

endmodule

// File: rtl/mxp_pin_map.sv
module mxp_pin_map
   import mxp_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int PIN_W  = 16,
   parameter int DATA_W = 32,
   parameter int BEAT_W = 2
) (
   input  mxp_phase_e        phase_i,
   input  logic              wide_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [BEAT_W-1:0] beat_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [PIN_W-1:0]  ad_o,
   output logic [1:0]        ad_oe_o
);

   localparam int HALF = PIN_W / 2;

   logic [HALF-1:0]  wbyte;
   logic [PIN_W-1:0] whalf;

   assign wbyte = wdata_i[HALF*beat_i +: HALF];
   assign whalf = wdata_i[PIN_W*beat_i[0] +: PIN_W];

   always_comb begin
      ad_o    = '0;
      ad_oe_o = 2'b00;
      unique case (phase_i)
         PH_LATCH: begin
            ad_o    = mxp_tag(addr_i, wide_i);
            ad_oe_o = 2'b11;
         end
         PH_STROBE: begin
            if (wide_i) begin
               ad_o    = we_i ? whalf : '0;
               ad_oe_o = we_i ? 2'b11 : 2'b00;
            end else begin
               ad_o    = {addr_i[HALF-1:0], (we_i ? wbyte : {HALF{1'b0}})};
               ad_oe_o = we_i ? 2'b11 : 2'b10;
            end
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/mux_ad_port.sv
module mux_ad_port
   import mxp_pkg::*;
#(
   parameter int ADDR_W     = 24,
   parameter int PIN_W      = 16,
   parameter int DATA_W     = 32,
   parameter int LEN_W      = 5,
   parameter int MIN_STROBE = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cfg_en_i,
   input  logic              cfg_ale_low_i,
   input  logic [LEN_W-1:0]  cfg_strobe_i,
   input  logic              req_i,
   input  logic              req_we_i,
   input  logic              req_wide_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic [DATA_W-1:0] req_wdata_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [DATA_W-1:0] rdata_o,
   output logic              ale_o,
   output logic              rd_n_o,
   output logic              wr_n_o,
   output logic [PIN_W-1:0]  ad_o,
   output logic [1:0]        ad_oe_o,
   input  logic [PIN_W-1:0]  ad_i
);

   localparam int LANES  = DATA_W / 8;
   localparam int BEAT_W = $clog2(LANES);
   localparam int NARROW = LANES;
   localparam int WIDE   = DATA_W / PIN_W;

   if (ADDR_W != 24 || PIN_W != 16 || DATA_W != 32) begin : g_bad_geom
      $error("mux_ad_port: pin mapping is defined for 24/16/32 only");
   end
   if (MIN_STROBE < 2 || LEN_W < 2) begin : g_bad_len
      $error("mux_ad_port: strobe length parameters out of range");
   end

   mxp_phase_e        ph_q, ph_d;
   logic [BEAT_W-1:0] beat_q, beat_d;
   logic [ADDR_W-1:0] base_q, cur_addr;
   logic [DATA_W-1:0] wdata_q;
   logic              we_q, wide_q, fin_q, done_q;
   logic              last_beat, tag_hit, strobe_last, timer_start, capture;
   logic              look_wide;
   logic [15:0]       look_tag;

   assign cur_addr  = wide_q ? {{(ADDR_W-PIN_W){1'b0}}, base_q[PIN_W-1:0] + PIN_W'(beat_q)}
                             : base_q + ADDR_W'(beat_q);
   assign last_beat = wide_q ? (beat_q == BEAT_W'(WIDE-1)) : (beat_q == BEAT_W'(NARROW-1));
   assign look_wide = (ph_q == PH_IDLE) ? req_wide_i : wide_q;
   assign look_tag  = mxp_tag((ph_q == PH_IDLE) ? req_addr_i : cur_addr, look_wide);

   mxp_tag_track #(.TAG_W(16)) u_track (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .upd_i  (ph_q == PH_LATCH),
      .wide_i (look_wide),
      .tag_i  (look_tag),
      .hit_o  (tag_hit)
   );

   always_comb begin
      ph_d   = ph_q;
      beat_d = beat_q;
      unique case (ph_q)
         PH_IDLE: if (req_i) begin
            ph_d   = tag_hit ? PH_STROBE : PH_LATCH;
            beat_d = '0;
         end
         PH_LATCH:  ph_d = PH_STROBE;
         PH_STROBE: if (strobe_last) begin
            ph_d = PH_RECOV;
            if (!last_beat) beat_d = beat_q + BEAT_W'(1);
         end
         PH_RECOV:  ph_d = fin_q ? PH_IDLE : (tag_hit ? PH_STROBE : PH_LATCH);
         default:   ph_d = PH_IDLE;
      endcase
      if (!cfg_en_i) ph_d = PH_IDLE;
   end

   assign timer_start = (ph_d == PH_STROBE) && (ph_q != PH_STROBE);
   assign capture     = (ph_q == PH_STROBE) && strobe_last && !we_q && cfg_en_i;

   mxp_strobe_timer #(.LEN_W(LEN_W), .MIN_LEN(MIN_STROBE)) u_timer (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (timer_start),
      .len_i   (cfg_strobe_i),
      .last_o  (strobe_last)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ph_q    <= PH_IDLE;
         beat_q  <= '0;
         base_q  <= '0;
         wdata_q <= '0;
         we_q    <= 1'b0;
         wide_q  <= 1'b0;
         fin_q   <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         ph_q   <= ph_d;
         beat_q <= beat_d;
         done_q <= (ph_q == PH_STROBE) && strobe_last && last_beat && cfg_en_i;
         if (ph_q == PH_IDLE && req_i && cfg_en_i) begin
            base_q  <= req_addr_i;
            wdata_q <= req_wdata_i;
            we_q    <= req_we_i;
            wide_q  <= req_wide_i;
            fin_q   <= 1'b0;
         end else if (ph_q == PH_STROBE && strobe_last && last_beat) begin
            fin_q <= 1'b1;
         end
      end
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic       lane_hit;
      logic [7:0] lane_q;
      assign lane_hit = capture && (wide_q ? (beat_q == BEAT_W'(g / 2))
                                           : (beat_q == BEAT_W'(g)));
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)       lane_q <= '0;
         else if (lane_hit) lane_q <= wide_q ? ad_i[8*(g%2) +: 8] : ad_i[7:0];
      end
      assign rdata_o[8*g +: 8] = lane_q;
   end

   mxp_pin_map #(.ADDR_W(ADDR_W), .PIN_W(PIN_W), .DATA_W(DATA_W), .BEAT_W(BEAT_W)) u_pins (
      .phase_i (ph_q),
      .wide_i  (wide_q),
      .we_i    (we_q),
      .addr_i  (cur_addr),
      .beat_i  (beat_q),
      .wdata_i (wdata_q),
      .ad_o    (ad_o),
      .ad_oe_o (ad_oe_o)
   );

   assign busy_o = (ph_q != PH_IDLE);
   assign done_o = done_q;
   assign rd_n_o = !((ph_q == PH_STROBE) && !we_q);
   assign wr_n_o = !((ph_q == PH_STROBE) && we_q);
   assign ale_o  = (ph_q == PH_LATCH) ^ cfg_ale_low_i;

   // R10
   off_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cfg_en_i |=> !busy_o && rd_n_o && wr_n_o);
   // R2
   ale_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ale_o ^ cfg_ale_low_i) |-> (rd_n_o && wr_n_o && ad_oe_o == 2'b11));
   // R5
   latch_then_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((ale_o ^ cfg_ale_low_i) && cfg_en_i) |=> (!rd_n_o || !wr_n_o));
   // R9
   read_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_n_o |-> (ad_oe_o[0] == 1'b0));
   // R8
   done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

endmodule

// File: tb/mux_ad_port_tb_top.sv
module mux_ad_port_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0, ale_low = 1'b0;
   logic [4:0]  slen = 5'd2;
   logic        req = 1'b0, req_we = 1'b0, req_wide = 1'b0;
   logic [23:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        busy, done, ale, rd_n, wr_n;
   logic [31:0] rdata;
   logic [15:0] ad_o, ad_i;
   logic [1:0]  ad_oe;

   always #2.5 clk = ~clk;

   mux_ad_port dut_i (
      .clk_i(clk), .rst_ni(rst_n), .cfg_en_i(en), .cfg_ale_low_i(ale_low),
      .cfg_strobe_i(slen), .req_i(req), .req_we_i(req_we), .req_wide_i(req_wide),
      .req_addr_i(req_addr), .req_wdata_i(req_wdata), .busy_o(busy), .done_o(done),
      .rdata_o(rdata), .ale_o(ale), .rd_n_o(rd_n), .wr_n_o(wr_n), .ad_o(ad_o),
      .ad_oe_o(ad_oe), .ad_i(ad_i)
   );

   int n_chk = 0, n_fail = 0;

   task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
      end
   endtask

   function automatic logic [7:0] mem8(input logic [23:0] a);
      return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
   endfunction
   function automatic logic [15:0] mem16(input logic [15:0] a);
      return {a[7:0], a[15:8]} ^ 16'hA55A;
   endfunction

   // external latch and device model
   logic [15:0] lat = '0;
   bit          cur_wide = 1'b0;
   int          ale_cnt = 0, rec_n = 0, done_cnt = 0, oe_bad = 0, wcnt = 0;
   logic [23:0] rec_addr [4];
   logic [15:0] rec_data [4];
   int          rec_w [4];
   logic [23:0] m_addr;
   logic [15:0] m_data;

   assign ad_i = cur_wide ? mem16(lat) : {8'h00, mem8({lat, ad_o[15:8]})};

   always @(negedge clk) if (rst_n) begin
      if (ale ^ ale_low) begin
         lat = ad_o;
         ale_cnt++;
      end
      if (done) done_cnt++;
      if (!rd_n || !wr_n) begin
         wcnt++;
         m_addr = cur_wide ? {8'h00, lat} : {lat, ad_o[15:8]};
         m_data = cur_wide ? ad_o : {8'h00, ad_o[7:0]};
         if (!wr_n ? (ad_oe != 2'b11) : (ad_oe != (cur_wide ? 2'b00 : 2'b10))) oe_bad++;
      end else if (wcnt > 0) begin
         if (rec_n < 4) begin
            rec_addr[rec_n] = m_addr;
            rec_data[rec_n] = m_data;
            rec_w[rec_n]    = wcnt;
         end
         rec_n++;
         wcnt = 0;
      end
   end

   // independent model of the remembered latch contents
   bit          tb_valid = 1'b0, tb_wide = 1'b0;
   logic [15:0] tb_tag = '0;

   task automatic clear_mon();
      ale_cnt = 0; rec_n = 0; done_cnt = 0; oe_bad = 0;
   endtask

   task automatic run_req(input bit wide, input bit we, input logic [23:0] a,
                          input logic [31:0] wd, input int len);
      int          nb, eff, exp_lat;
      logic [23:0] ea [4];
      logic [15:0] tg;
      logic [31:0] exp_rd;
      string       am;
      nb = wide ? 2 : 4;
      eff = (len < 2) ? 2 : len;
      exp_lat = 0;
      exp_rd = '0;
      am = wide ? "R4" : "R2,R3";
      for (int k = 0; k < nb; k++) begin
         if (wide) begin
            ea[k] = {8'h00, a[15:0] + 16'(k)};
            tg = ea[k][15:0];
            exp_rd[16*k +: 16] = mem16(ea[k][15:0]);
         end else begin
            ea[k] = a + 24'(k);
            tg = ea[k][23:8];
            exp_rd[8*k +: 8] = mem8(ea[k]);
         end
         if (!(tb_valid && tb_wide == wide && tb_tag == tg)) exp_lat++;
         tb_valid = 1'b1; tb_wide = wide; tb_tag = tg;
      end
      @(negedge clk); #1;
      clear_mon();
      cur_wide = wide;
      req_wide = wide; req_we = we; req_addr = a; req_wdata = wd; slen = 5'(len);
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      for (int c = 0; c < 400; c++) begin
         @(negedge clk); #1;
         if (done_cnt > 0) break;
      end
      chk(done_cnt == 1, "R8 done pulse", 32'(done_cnt), 32'd1);
      chk(rec_n == nb, wide ? "R4 transfer count" : "R3 transfer count", 32'(rec_n), 32'(nb));
      chk(ale_cnt == exp_lat, "R5 latch count", 32'(ale_cnt), 32'(exp_lat));
      chk(oe_bad == 0, "R9 lane enables", 32'(oe_bad), 32'd0);
      for (int k = 0; k < nb && k < rec_n; k++) begin
         chk(rec_addr[k] == ea[k], am, 32'(rec_addr[k]), 32'(ea[k]));
         chk(rec_w[k] == eff, "R6 strobe width", 32'(rec_w[k]), 32'(eff));
         if (we) begin
            if (wide) chk(rec_data[k] == wd[16*k +: 16], "R8 write half", 32'(rec_data[k]), 32'(wd[16*k +: 16]));
            else      chk(rec_data[k][7:0] == wd[8*k +: 8], "R8 write byte", 32'(rec_data[k]), 32'(wd[8*k +: 8]));
         end
      end
      if (!we) chk(rdata == exp_rd, "R8 read pack", rdata, exp_rd);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int lens [5] = '{0, 1, 3, 7, 31};
      logic [23:0] addrs [4] = '{24'h0001FE, 24'h000100, 24'h000101, 24'hFFFFFE};
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(rd_n && wr_n, "R1 strobes", {30'd0, rd_n, wr_n}, 32'd3);
      chk(ale == 1'b0, "R1 latch strobe", 32'(ale), 32'd0);
      chk(ad_oe == 2'b00 && !busy, "R1 lanes/busy", {29'd0, busy, ad_oe}, 32'd0);
      rst_n = 1'b1;
      en = 1'b1;
      @(negedge clk);

      for (int w = 0; w < 2; w++)
         for (int we = 0; we < 2; we++)
            for (int l = 0; l < 5; l++)
               for (int ai = 0; ai < 4; ai++)
                  run_req(w[0], we[0], addrs[ai], 32'hC3A5_1E87 ^ {addrs[ai], 8'(l)}, lens[l]);

      // R7 inverted latch strobe polarity
      @(negedge clk); #1;
      ale_low = 1'b1;
      @(negedge clk);
      chk(ale == 1'b1, "R7 idle level inverted", 32'(ale), 32'd1);
      run_req(!tb_wide, 1'b0, 24'h3456AB, 32'h0, 4);
      run_req(tb_wide, 1'b1, 24'h3456AB, 32'h89AB_CDEF, 2);
      @(negedge clk); #1;
      ale_low = 1'b0;

      // R10 request while disabled is ignored
      en = 1'b0;
      clear_mon();
      req_wide = !tb_wide; req_we = 1'b1; req_addr = 24'h777777;
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      repeat (10) @(negedge clk);
      #1;
      chk(rec_n == 0 && ale_cnt == 0 && done_cnt == 0 && !busy, "R10 ignored while off",
          32'(rec_n + ale_cnt + done_cnt), 32'd0);
      en = 1'b1;
      run_req(tb_wide, 1'b0, tb_wide ? {8'h00, tb_tag} : {tb_tag, 8'h00}, 32'h0, 2);

      // R10 abort mid access, then R5 hit on the latched portion
      @(negedge clk); #1;
      clear_mon();
      cur_wide = !tb_wide;
      req_wide = cur_wide; req_we = 1'b0; req_addr = 24'h123456; slen = 5'd31;
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      repeat (5) @(negedge clk);
      #1;
      en = 1'b0;
      @(negedge clk); #1;
      chk(!busy && rd_n && wr_n, "R10 abort to idle", {29'd0, busy, rd_n, wr_n}, 32'd3);
      tb_valid = 1'b1; tb_wide = cur_wide;
      tb_tag = cur_wide ? 16'h3456 : 16'h1234;
      en = 1'b1;
      run_req(cur_wide, 1'b1, 24'h123456, 32'h0BAD_F00D, 5);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule